// File: doc/BRIEF.md
# Narrow-to-wide burst packing bridge

This bridge sits between a 32-bit bursting master port and a 64-bit bursting slave port. It converts the burst instead of splitting it. Narrow write beats are paired into wide beats, so a write burst of n narrow beats leaves as a wide burst of about n/2 beats rather than as n single accesses. A read burst is sent as one wide read burst. Each returned wide word is then given back to the master as one or two narrow beats, lower half first.

The wide address is the narrow start address with its low three bits cleared. Address bit 2 selects the half in which the burst begins, so a burst that starts on the upper half, or that has an odd length, produces a wide beat with only one half enabled.

A lower half can sit waiting for its partner. If no partner arrives within a parameterised number of cycles, the bridge flushes that half on its own, ends the wide burst there, and sends the remaining narrow beats as a fresh wide burst. A stalled master therefore never holds a wide transfer hostage. Only one burst is handled at a time.

Top module: `burst_pack_bridge`

## Requirements
- R1: After reset, `s_write`, `s_read` and `m_rvalid` are low, and `m_wait` is low while the master requests nothing.
- R2: A write burst of n beats starting at byte address A, with off = A bit 2, leaves as ceil((off+n)/2) wide beats. The first wide beat has address A with bits 2:0 cleared, and each following wide beat is 8 bytes higher (when no timeout occurs).
- R3: Every wide write beat carries on `s_burst` the number of wide beats left in its wide burst, counting itself: W, W-1, ..., 1.
- R4: Narrow write beat i goes to slot p = off+i. It lands in wide beat p/2, in bits 31:0 when p is even and in bits 63:32 when p is odd.
- R5: Each half of `s_be` copies the `m_be` of the narrow beat placed there. A half with no beat has enables 0000 and data zero.
- R6: While a wide write is pending and `s_wait` is high, `m_wait` is high for write beats, and `s_wdata`, `s_be`, `s_addr` and `s_burst` hold. No beat is lost or repeated.
- R7: Suppose a lower half has been held for TIMEOUT cycles with no further beat. The bridge then issues it alone with `s_burst` = 1. The r remaining narrow beats form a new wide burst at the next wide address. That burst starts in the upper half and has floor(r/2)+1 beats.
- R8: A narrow beat accepted within TIMEOUT cycles of its lower partner merges into the same wide beat.
- R9: A read burst of n beats at A produces one `s_read` command with address A with bits 2:0 cleared and `s_burst` = ceil((off+n)/2). The command holds until `s_wait` is low.
- R10: A read returns exactly n narrow beats on `m_rdata`, in slot order. Slot p takes bits 31:0 of returned wide word p/2 when p is even and bits 63:32 when p is odd.
- R11: While a read burst is outstanding, a new master request sees `m_wait` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_addr | input | AW | Master byte address, sampled on a burst's first beat |
| m_burst | input | BW | Master burst length in narrow beats |
| m_write | input | 1 | Master write beat request |
| m_wdata | input | 32 | Master write data |
| m_be | input | 4 | Master byte enables |
| m_read | input | 1 | Master read command |
| m_wait | output | 1 | Stall to master; the request is not taken while high |
| m_rdata | output | 32 | Narrow read data |
| m_rvalid | output | 1 | Narrow read data valid |
| s_addr | output | AW | Wide byte address, 8-byte aligned |
| s_burst | output | BW | Wide burst count (writes: beats left including this one) |
| s_write | output | 1 | Wide write beat valid |
| s_wdata | output | 64 | Wide write data |
| s_be | output | 8 | Wide byte enables |
| s_read | output | 1 | Wide read command |
| s_wait | input | 1 | Stall from slave |
| s_rdata | input | 64 | Wide read data |
| s_rvalid | input | 1 | Wide read data valid |

## Verification
The hardest state to reach is the timeout flush in the middle of a burst. The master has to deliver a lower-half beat and then go quiet for longer than TIMEOUT cycles before finishing the same burst. The bench reaches it by inserting an idle gap after the first beat of a burst: TIMEOUT+2 cycles to force the split, and TIMEOUT-3 cycles to show that merging still happens. Backpressure with a full packing register is reached by a periodic slave stall pattern, applied across every start half and burst length from 1 to 9.

// File: rtl/burst_pack_bridge.sv
module burst_pack_bridge #(
  parameter int AW = 16,
  parameter int BW = 5,
  parameter int TIMEOUT = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] m_addr,
  input  logic [BW-1:0] m_burst,
  input  logic          m_write,
  input  logic [31:0]   m_wdata,
  input  logic [3:0]    m_be,
  input  logic          m_read,
  output logic          m_wait,
  output logic [31:0]   m_rdata,
  output logic          m_rvalid,
  output logic [AW-1:0] s_addr,
  output logic [BW-1:0] s_burst,
  output logic          s_write,
  output logic [63:0]   s_wdata,
  output logic [7:0]    s_be,
  output logic          s_read,
  input  logic          s_wait,
  input  logic [63:0]   s_rdata,
  input  logic          s_rvalid
);
  localparam int TW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam int PW = BW - 1;
  localparam int RD = 1 << PW;

  logic          wv, lo_held, wflush, half;
  logic [BW-1:0] nrem, bcur;
  logic [63:0]   wd;
  logic [7:0]    wbe;
  logic [AW-1:0] wa;
  logic [TW-1:0] tmr;

  logic          rq, ract, rhalf;
  logic [BW-1:0] rbc, rnrem, cnt;
  logic [AW-1:0] ra;
  logic [63:0]   fifo [RD];
  logic [PW-1:0] wp, rp;

  wire wact = nrem != '0;
  assign m_wait = (m_write && (ract || (wv && s_wait))) ||
                  (m_read && (ract || wact || wv));
  wire wr_acc = m_write && !m_wait;
  wire rd_acc = m_read && !m_wait;

  wire [AW-1:0] alig = m_addr & ~AW'(7);
  wire [BW-1:0] first_cnt = BW'(({1'b0, m_burst} + {{BW{1'b0}}, m_addr[2]} + (BW+1)'(1)) >> 1);

  wire          first    = !wact;
  wire          h        = first ? m_addr[2] : half;
  wire [BW-1:0] nbeats   = first ? m_burst : nrem;
  wire          last     = nbeats == BW'(1);
  wire          issuing  = wv && !s_wait;
  wire [AW-1:0] wa_nx    = wa + AW'(8);
  wire [AW-1:0] beat_adr = first ? alig : ((!lo_held && issuing) ? wa_nx : wa);
  wire [63:0]   base_d   = lo_held ? wd : 64'd0;
  wire [7:0]    base_be  = lo_held ? wbe : 8'd0;
  wire [63:0]   mrg_d    = h ? {m_wdata, base_d[31:0]} : {base_d[63:32], m_wdata};
  wire [7:0]    mrg_be   = h ? {m_be, base_be[3:0]} : {base_be[7:4], m_be};
  wire          expire   = lo_held && !wr_acc && tmr == TW'(TIMEOUT - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wv <= 1'b0; lo_held <= 1'b0; wflush <= 1'b0; half <= 1'b0;
      nrem <= '0; bcur <= '0; wd <= '0; wbe <= '0; wa <= '0; tmr <= '0;
    end else begin
      if (issuing) begin
        wv     <= 1'b0;
        wflush <= 1'b0;
        wa     <= wa_nx;
        bcur   <= wflush ? (nrem >> 1) + BW'(1) : bcur - BW'(1);
      end
      if (wr_acc) begin
        wd   <= mrg_d;
        wbe  <= mrg_be;
        wa   <= beat_adr;
        half <= ~h;
        nrem <= nbeats - BW'(1);
        if (first) bcur <= first_cnt;
        if (h || last) begin
          wv <= 1'b1; lo_held <= 1'b0;
        end else begin
          lo_held <= 1'b1; tmr <= '0;
        end
      end else if (expire) begin
        wv <= 1'b1; lo_held <= 1'b0; wflush <= 1'b1;
      end else if (lo_held) begin
        tmr <= tmr + TW'(1);
      end
    end
  end

  assign s_write = wv;
  assign s_wdata = wd;
  assign s_be    = wbe;
  assign s_read  = rq;
  assign s_addr  = rq ? ra : wa;
  assign s_burst = rq ? rbc : (wflush ? BW'(1) : bcur);

  assign m_rvalid = cnt != '0;
  assign m_rdata  = rhalf ? fifo[rp][63:32] : fifo[rp][31:0];
  wire pop = m_rvalid && (rhalf || rnrem == BW'(1));

  always_ff @(posedge clk) begin
    if (s_rvalid) fifo[wp] <= s_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rq <= 1'b0; ract <= 1'b0; rhalf <= 1'b0; rbc <= '0; rnrem <= '0;
      ra <= '0; wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (rd_acc) begin
        rq <= 1'b1; ract <= 1'b1; ra <= alig; rbc <= first_cnt;
        rhalf <= m_addr[2]; rnrem <= m_burst;
      end else begin
        if (rq && !s_wait) rq <= 1'b0;
        if (m_rvalid) begin
          rhalf <= ~rhalf;
          rnrem <= rnrem - BW'(1);
          if (rnrem == BW'(1)) ract <= 1'b0;
        end
      end
      if (s_rvalid) wp <= wp + PW'(1);
      if (pop) rp <= rp + PW'(1);
      cnt <= cnt + BW'(s_rvalid) - BW'(pop);
    end
  end

  p_hold_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    s_write && s_wait |=> s_write && $stable(s_wdata) && $stable(s_be) && $stable(s_addr) && $stable(s_burst));
  p_wait_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    m_write && s_write && s_wait |-> m_wait);
  p_flush_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> s_write && s_burst == BW'(1) && s_be[7:4] == 4'h0);
  p_be_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
    s_write |-> s_be != 8'h00);
  p_one_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_read && s_write));
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid |-> cnt < BW'(RD));
  p_rdata_in_burst_r10: assert property (@(posedge clk) disable iff (!rst_n)
    m_rvalid |-> ract);
endmodule

// File: tb/burst_pack_bridge_tb_top.sv
module burst_pack_bridge_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16, BW = 5, TO = 8;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] m_addr = '0; logic [BW-1:0] m_burst = '0;
  logic m_write = 0, m_read = 0; logic [31:0] m_wdata = '0; logic [3:0] m_be = '0;
  logic m_wait, m_rvalid; logic [31:0] m_rdata;
  logic [AW-1:0] s_addr; logic [BW-1:0] s_burst; logic s_write, s_read;
  logic [63:0] s_wdata; logic [7:0] s_be;
  logic s_wait = 0, s_rvalid = 0; logic [63:0] s_rdata = '0;

  burst_pack_bridge #(.AW(AW), .BW(BW), .TIMEOUT(TO)) dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, stall_en = 0;
  int wr_cnt = 0, rd_cnt = 0, cmd_cnt = 0, wait_bad = 0, wait_seen = 0;
  logic [AW-1:0] wr_addr [1024]; logic [63:0] wr_data [1024];
  logic [7:0] wr_be [1024]; logic [BW-1:0] wr_bc [1024];
  logic [31:0] rd_data [1024]; logic [AW-1:0] cmd_addr; logic [BW-1:0] cmd_bc;

  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) #1 s_wait = (stall_en != 0) && ((cyc % 3) == 0);

  always @(negedge clk) if (rst_n) begin
    if (s_write && !s_wait) begin
      wr_addr[wr_cnt] = s_addr; wr_data[wr_cnt] = s_wdata;
      wr_be[wr_cnt] = s_be; wr_bc[wr_cnt] = s_burst; wr_cnt++;
    end
    if (m_write && s_write && s_wait) begin
      wait_seen++; if (!m_wait) wait_bad++;
    end
    if (s_read && !s_wait) begin cmd_addr = s_addr; cmd_bc = s_burst; cmd_cnt++; end
    if (m_rvalid) begin rd_data[rd_cnt] = m_rdata; rd_cnt++; end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual %h expected %h", req, act, exp); end
  endtask

  function automatic logic [31:0] pat(int tid, int i);
    return {8'hA5, 8'(tid), 8'(i), 8'(i * 7 + 3)};
  endfunction
  function automatic logic [3:0] bep(int i);
    return (i % 4 == 3) ? 4'b0011 : ((i % 4 == 1) ? 4'b1100 : 4'b1111);
  endfunction

  task automatic wr_burst(input logic [AW-1:0] a, input int n, input int tid, input int gap);
    for (int i = 0; i < n; i++) begin
      if (i == 1 && gap > 0) begin
        @(posedge clk) #1 m_write = 0;
        repeat (gap - 1) @(posedge clk);
      end
      @(posedge clk) #1;
      m_write = 1; m_addr = a; m_burst = BW'(n); m_wdata = pat(tid, i); m_be = bep(i);
      @(negedge clk); while (m_wait) @(negedge clk);
    end
    @(posedge clk) #1 m_write = 0;
    repeat (8) @(posedge clk);
  endtask

  // normal packing: slot p = off+i, word p/2, half p%2
  task automatic wr_test(input int off, input int n, input int tid, input int gap, input string tag);
    logic [AW-1:0] a = AW'(16'h0400 + tid * 64 + off * 4);
    logic [AW-1:0] al = a & ~AW'(7);
    int w = (off + n + 1) / 2;
    int b0 = wr_cnt;
    wr_burst(a, n, tid, gap);
    chk(wr_cnt - b0 == w, {tag, " R2 wide beat count"}, 64'(wr_cnt - b0), 64'(w));
    for (int k = 0; k < w && b0 + k < wr_cnt; k++) begin
      logic [63:0] ed = '0; logic [7:0] eb = '0;
      for (int i = 0; i < n; i++) if ((off + i) / 2 == k) begin
        if ((off + i) % 2 == 1) begin ed[63:32] = pat(tid, i); eb[7:4] = bep(i); end
        else begin ed[31:0] = pat(tid, i); eb[3:0] = bep(i); end
      end
      chk(wr_addr[b0+k] == al + AW'(8 * k), {tag, " R2 address"}, 64'(wr_addr[b0+k]), 64'(al + AW'(8 * k)));
      chk(wr_bc[b0+k] == BW'(w - k), {tag, " R3 burst count"}, 64'(wr_bc[b0+k]), 64'(w - k));
      chk(wr_data[b0+k] == ed, {tag, " R4 lane data"}, wr_data[b0+k], ed);
      chk(wr_be[b0+k] == eb, {tag, " R5 byte enables"}, 64'(wr_be[b0+k]), 64'(eb));
    end
  endtask

  // R7: flush after beat 0 (off=0); beat i>=1 lands in slot q=i+2
  task automatic flush_test(input int n, input int tid);
    logic [AW-1:0] a = AW'(16'h0400 + tid * 64);
    int w2 = (n - 1) / 2 + 1;
    int b0 = wr_cnt;
    wr_burst(a, n, tid, TO + 2);
    chk(wr_cnt - b0 == 1 + w2, "R7 total beats", 64'(wr_cnt - b0), 64'(1 + w2));
    chk(wr_bc[b0] == 1, "R7 flushed count", 64'(wr_bc[b0]), 64'd1);
    chk(wr_data[b0] == {32'd0, pat(tid, 0)}, "R7 flushed data", wr_data[b0], {32'd0, pat(tid, 0)});
    chk(wr_be[b0] == {4'h0, bep(0)}, "R7 flushed enables", 64'(wr_be[b0]), 64'({4'h0, bep(0)}));
    for (int k = 1; k <= w2 && b0 + k < wr_cnt; k++) begin
      logic [63:0] ed = '0; logic [7:0] eb = '0;
      for (int i = 1; i < n; i++) if ((i + 2) / 2 == k) begin
        if ((i + 2) % 2 == 1) begin ed[63:32] = pat(tid, i); eb[7:4] = bep(i); end
        else begin ed[31:0] = pat(tid, i); eb[3:0] = bep(i); end
      end
      chk(wr_addr[b0+k] == a + AW'(8 * k), "R7 address", 64'(wr_addr[b0+k]), 64'(a + AW'(8 * k)));
      chk(wr_bc[b0+k] == BW'(w2 - k + 1), "R7 new burst count", 64'(wr_bc[b0+k]), 64'(w2 - k + 1));
      chk(wr_data[b0+k] == ed, "R7 data", wr_data[b0+k], ed);
      chk(wr_be[b0+k] == eb, "R7 enables", 64'(wr_be[b0+k]), 64'(eb));
    end
  endtask

  task automatic rd_test(input int off, input int n, input int tid);
    logic [AW-1:0] a = AW'(16'h2000 + tid * 128 + off * 4);
    logic [AW-1:0] al = a & ~AW'(7);
    int w = (off + n + 1) / 2;
    int r0 = rd_cnt, c0 = cmd_cnt;
    @(posedge clk) #1; m_read = 1; m_addr = a; m_burst = BW'(n);
    @(negedge clk); while (m_wait) @(negedge clk);
    @(posedge clk) #1 m_read = 0;
    while (cmd_cnt == c0) @(negedge clk);
    chk(cmd_addr == al, "R9 read address", 64'(cmd_addr), 64'(al));
    chk(cmd_bc == BW'(w), "R9 read count", 64'(cmd_bc), 64'(w));
    @(posedge clk) #1 m_read = 1;
    @(negedge clk) chk(m_wait == 1, "R11 wait during read", 64'(m_wait), 64'd1);
    @(posedge clk) #1 m_read = 0;
    for (int k = 0; k < w; k++) begin
      s_rvalid = 1;
      s_rdata = {32'h2000_0000 + 32'(al) + 32'(8 * k + 4), 32'h1000_0000 + 32'(al) + 32'(8 * k)};
      @(posedge clk) #1;
    end
    s_rvalid = 0;
    repeat (2 * w + 6) @(posedge clk);
    chk(rd_cnt - r0 == n, "R10 read beat count", 64'(rd_cnt - r0), 64'(n));
    for (int i = 0; i < n && r0 + i < rd_cnt; i++) begin
      logic [31:0] e = (((off + i) % 2) ? 32'h2000_0000 : 32'h1000_0000) + 32'(a) + 32'(4 * i);
      chk(rd_data[r0+i] == e, "R10 read data", 64'(rd_data[r0+i]), 64'(e));
    end
  endtask

  initial begin
    bit hung = 0;
    fork
      begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk(!s_write && !s_read && !m_rvalid && !m_wait, "R1 reset outputs",
            64'({s_write, s_read, m_rvalid, m_wait}), 64'd0);
        for (int st = 0; st < 2; st++) begin
          stall_en = st;
          for (int off = 0; off < 2; off++)
            for (int n = 1; n <= 9; n++) begin
              wr_test(off, n, st * 20 + off * 10 + n, 0, "sweep");
              rd_test(off, n, st * 20 + off * 10 + n);
            end
        end
        chk(wait_seen > 0 && wait_bad == 0, "R6 wait under stall", 64'(wait_bad), 64'd0);
        stall_en = 0;
        wr_test(0, 4, 41, TO - 3, "R8 late merge");
        wr_test(0, 7, 42, TO - 3, "R8 late merge");
        flush_test(4, 43);
        flush_test(3, 44);
        flush_test(6, 45);
      end
      begin
        repeat (150000) @(posedge clk);
        hung = 1;
      end
    join_any
    disable fork;
    if (hung) begin checks++; errors++; $display("FAIL watchdog expired"); end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule